// File: doc/BRIEF.md
# Virtual-Channel Input Unit Controller

This block controls one input port of a pipelined virtual-channel router. Each virtual channel (VC) on the port has its own flit buffer and a state record: a global state, the output port chosen by route computation, the output VC won in VC allocation, and the buffer pointers. Credit counters for the downstream output VCs are kept in a shared bank. Head flits take the VC through routing, waiting-for-VC and active states. Body and tail flits wait in the buffer. Every flit leaves only after it wins a switch slot.

Route computation and the allocators sit outside the block. The block raises a per-VC routing request while a VC is in the routing state. It raises a per-VC VC-allocation request while the VC waits for an output VC. It raises a per-VC switch bid when the VC can move a flit. The external logic answers with strobes. When a switch grant arrives, the block presents the flit at the head of that VC's buffer on its output in the same cycle. The flit is tagged with the recorded output port and output VC. Returned credits refill the counter of the matching output VC.

Top module: `vcu_input_unit`

## Requirements
- R1: After synchronous reset, every VC is idle: no routing request, no VC-allocation request, no switch bid, no output flit, and the overflow flag is 0. Every output-VC credit counter holds CRED_MAX.
- R2: A head flit (type 00, or 11 for head-and-tail) written to an idle VC is stored in that VC's buffer. From the next cycle, that VC's routing request is high.
- R3: A route-done strobe during routing records the output port and moves the VC to waiting-for-VC. The VC-allocation request is high from the next cycle. Every flit of the packet leaves tagged with that port.
- R4: A VC grant while waiting records exactly one output VC and makes the VC active from the next cycle. Every flit of the packet leaves tagged with that output VC.
- R5: A VC bids for the switch only when it is active, its buffer holds at least one flit, and the credit count of its output VC is above zero.
- R6: On a switch grant, the oldest buffered flit of that VC appears on the output in the same cycle with out_valid high. The read pointer advances, and the output VC's credit count drops by one.
- R7: Each credit return adds one to the credit count of the output VC it names.
- R8: A switch grant and a credit return on the same output VC in the same cycle leave that credit count unchanged.
- R9: When a tail flit (type 10 or 11) is forwarded, the VC goes to idle if no flit remains in its buffer. If another head flit is already buffered, the VC goes straight to routing and its routing request is high from the next cycle.
- R10: Body (01) and tail flits arriving at a VC that is not idle change no state. They raise no routing or VC-allocation request.
- R11: A flit written to a full VC buffer is dropped and never forwarded. It sets a sticky overflow flag that only reset clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming flit strobe |
| in_vc | input | VCW | Input VC the flit belongs to |
| in_kind | input | 2 | Flit type: 00 head, 01 body, 10 tail, 11 head-and-tail |
| in_data | input | DW | Flit payload |
| rc_req | output | NVC | Per-VC routing request |
| rc_done | input | NVC | Per-VC route-done strobe |
| rc_port | input | PW | Output port from the routing stub |
| va_req | output | NVC | Per-VC output-VC request |
| va_grant | input | NVC | Per-VC output-VC grant strobe |
| va_ovc | input | OW | Granted output VC |
| sa_bid | output | NVC | Per-VC switch bid |
| sa_grant | input | NVC | One-hot switch grant |
| cr_valid | input | 1 | Credit return strobe |
| cr_ovc | input | OW | Output VC the credit belongs to |
| out_valid | output | 1 | Forwarded flit strobe |
| out_kind | output | 2 | Forwarded flit type |
| out_data | output | DW | Forwarded flit payload |
| out_port | output | PW | Output port of the forwarded flit |
| out_ovc | output | OW | Output VC of the forwarded flit |
| overflow | output | 1 | Sticky buffer-overflow flag |

## Verification
The bench builds the block with its defaults: two VCs of four flits each, four output ports, four output VCs and four credits per output VC. With four credits, four flits can drain an output VC to zero, so the no-credit stall, the credit refill and the simultaneous grant-and-return case all occur within a few cycles. With a four-flit buffer, a fifth write reaches the overflow case. Each buffer can also hold two short packets at once, so a tail can leave with the next head already waiting.

// File: rtl/vcu_pkg.sv
package vcu_pkg;

    typedef enum logic [1:0] {
        FK_HEAD   = 2'b00,
        FK_BODY   = 2'b01,
        FK_TAIL   = 2'b10,
        FK_SINGLE = 2'b11
    } flit_kind_e;

    typedef enum logic [1:0] {
        VS_IDLE   = 2'd0,
        VS_ROUTE  = 2'd1,
        VS_WAITVC = 2'd2,
        VS_ACTIVE = 2'd3
    } vc_state_e;

    function automatic logic kind_opens(input logic [1:0] k);
        return (k == FK_HEAD) || (k == FK_SINGLE);
    endfunction

    function automatic logic kind_closes(input logic [1:0] k);
        return (k == FK_TAIL) || (k == FK_SINGLE);
    endfunction

endpackage

// File: rtl/vcu_flit_fifo.sv
module vcu_flit_fifo #(
    parameter int DEPTH = 4,
    parameter int FW    = 18,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic [FW-1:0]   wdata,
    input  logic            pop,
    output logic [FW-1:0]   head,
    output logic [CNTW-1:0] count,
    output logic            push_ok,
    output logic            push_lost
);
    logic [FW-1:0] mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic          full, empty, pop_ok;

    assign full      = (count == CNTW'(DEPTH));
    assign empty     = (count == '0);
    assign push_ok   = push && !full;
    assign push_lost = push && full;
    assign pop_ok    = pop && !empty;
    assign head      = mem[rd_ptr];

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                mem[wr_ptr] <= wdata;
                wr_ptr      <= wrap_inc(wr_ptr);
            end
            if (pop_ok) rd_ptr <= wrap_inc(rd_ptr);
            count <= count + CNTW'(push_ok) - CNTW'(pop_ok);
        end
    end

    AST_FIFO_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);                                             // R6
    AST_FIFO_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> (count == CNTW'(DEPTH)));                  // R11

endmodule

// File: rtl/vcu_vc_ctrl.sv
module vcu_vc_ctrl
    import vcu_pkg::*;
#(
    parameter int PW   = 2,
    parameter int OW   = 2,
    parameter int CNTW = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push_ok,
    input  logic [1:0]      push_kind,
    input  logic            rc_done,
    input  logic [PW-1:0]   rc_port,
    input  logic            va_grant,
    input  logic [OW-1:0]   va_ovc,
    input  logic            sa_grant,
    input  logic [1:0]      head_kind,
    input  logic [CNTW-1:0] count,
    output vc_state_e       state,
    output logic [PW-1:0]   route,
    output logic [OW-1:0]   ovc
);
    logic [CNTW:0] left_after;
    logic          tail_leaves;

    assign tail_leaves = (state == VS_ACTIVE) && sa_grant && kind_closes(head_kind);
    assign left_after  = {1'b0, count} - (CNTW+1)'(1) + (CNTW+1)'(push_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= VS_IDLE;
            route <= '0;
            ovc   <= '0;
        end else begin
            unique case (state)
                VS_IDLE:   if (push_ok && kind_opens(push_kind)) state <= VS_ROUTE;
                VS_ROUTE:  if (rc_done) begin
                               route <= rc_port;
                               state <= VS_WAITVC;
                           end
                VS_WAITVC: if (va_grant) begin
                               ovc   <= va_ovc;
                               state <= VS_ACTIVE;
                           end
                VS_ACTIVE: if (tail_leaves)
                               state <= (left_after != '0) ? VS_ROUTE : VS_IDLE;
                default:   state <= VS_IDLE;
            endcase
        end
    end

    AST_HEAD_STARTS_ROUTE: assert property (@(posedge clk) disable iff (rst)
        (state == VS_IDLE && push_ok && kind_opens(push_kind)) |=> (state == VS_ROUTE)); // R2
    AST_ROUTE_TO_WAIT: assert property (@(posedge clk) disable iff (rst)
        (state == VS_ROUTE && rc_done) |=> (state == VS_WAITVC && route == $past(rc_port))); // R3
    AST_GRANT_TO_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (state == VS_WAITVC && va_grant) |=> (state == VS_ACTIVE && ovc == $past(va_ovc))); // R4
    AST_EMPTY_TAIL_IDLES: assert property (@(posedge clk) disable iff (rst)
        (tail_leaves && count == CNTW'(1) && !push_ok) |=> (state == VS_IDLE)); // R9
    AST_BODY_NO_WAKE: assert property (@(posedge clk) disable iff (rst)
        (state == VS_IDLE && !(push_ok && kind_opens(push_kind))) |=> (state == VS_IDLE)); // R10

endmodule

// File: rtl/vcu_credit_bank.sv
module vcu_credit_bank #(
    parameter int NOVC     = 4,
    parameter int CRED_MAX = 4,
    localparam int CW      = $clog2(CRED_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NOVC-1:0] inc,
    input  logic [NOVC-1:0] dec,
    output logic [NOVC-1:0] has_credit
);
    logic [CW-1:0] cnt [NOVC];

    for (genvar o = 0; o < NOVC; o++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst)                   cnt[o] <= CW'(CRED_MAX);
            else if (inc[o] && !dec[o]) cnt[o] <= cnt[o] + CW'(1);
            else if (dec[o] && !inc[o]) cnt[o] <= cnt[o] - CW'(1);
        end
        assign has_credit[o] = (cnt[o] != '0);

        AST_CREDIT_HOLD: assert property (@(posedge clk) disable iff (rst)
            (inc[o] && dec[o]) |=> (cnt[o] == $past(cnt[o])));           // R8
        AST_CREDIT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
            dec[o] |-> (cnt[o] != '0));                                   // R5
        AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (rst)
            cnt[o] <= CW'(CRED_MAX));                                     // R7
    end

endmodule

// File: rtl/vcu_input_unit.sv
module vcu_input_unit
    import vcu_pkg::*;
#(
    parameter int NVC      = 2,
    parameter int DEPTH    = 4,
    parameter int DW       = 16,
    parameter int NPORT    = 4,
    parameter int NOVC     = 4,
    parameter int CRED_MAX = 4,
    localparam int VCW     = (NVC > 1) ? $clog2(NVC) : 1,
    localparam int PW      = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int OW      = (NOVC > 1) ? $clog2(NOVC) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [VCW-1:0]  in_vc,
    input  logic [1:0]      in_kind,
    input  logic [DW-1:0]   in_data,
    output logic [NVC-1:0]  rc_req,
    input  logic [NVC-1:0]  rc_done,
    input  logic [PW-1:0]   rc_port,
    output logic [NVC-1:0]  va_req,
    input  logic [NVC-1:0]  va_grant,
    input  logic [OW-1:0]   va_ovc,
    output logic [NVC-1:0]  sa_bid,
    input  logic [NVC-1:0]  sa_grant,
    input  logic            cr_valid,
    input  logic [OW-1:0]   cr_ovc,
    output logic            out_valid,
    output logic [1:0]      out_kind,
    output logic [DW-1:0]   out_data,
    output logic [PW-1:0]   out_port,
    output logic [OW-1:0]   out_ovc,
    output logic            overflow
);
    localparam int FW   = 2 + DW;
    localparam int CNTW = $clog2(DEPTH + 1);

    vc_state_e       st       [NVC];
    logic [PW-1:0]   route    [NVC];
    logic [OW-1:0]   ovc      [NVC];
    logic [FW-1:0]   head     [NVC];
    logic [CNTW-1:0] count    [NVC];
    logic [NVC-1:0]  push, push_ok, push_lost, pop;
    logic [NOVC-1:0] cr_inc, cr_dec, has_credit;

    for (genvar v = 0; v < NVC; v++) begin : g_vc
        assign push[v] = in_valid && (in_vc == VCW'(v));
        assign pop[v]  = sa_grant[v] && sa_bid[v];

        vcu_flit_fifo #(.DEPTH(DEPTH), .FW(FW)) u_fifo (
            .clk(clk), .rst(rst),
            .push(push[v]), .wdata({in_kind, in_data}),
            .pop(pop[v]), .head(head[v]), .count(count[v]),
            .push_ok(push_ok[v]), .push_lost(push_lost[v])
        );

        vcu_vc_ctrl #(.PW(PW), .OW(OW), .CNTW(CNTW)) u_ctrl (
            .clk(clk), .rst(rst),
            .push_ok(push_ok[v]), .push_kind(in_kind),
            .rc_done(rc_done[v]), .rc_port(rc_port),
            .va_grant(va_grant[v]), .va_ovc(va_ovc),
            .sa_grant(pop[v]), .head_kind(head[v][FW-1 -: 2]),
            .count(count[v]),
            .state(st[v]), .route(route[v]), .ovc(ovc[v])
        );

        assign rc_req[v] = (st[v] == VS_ROUTE);
        assign va_req[v] = (st[v] == VS_WAITVC);
        assign sa_bid[v] = (st[v] == VS_ACTIVE) && (count[v] != '0) && has_credit[ovc[v]];
    end

    always_comb begin
        cr_inc = '0;
        cr_dec = '0;
        if (cr_valid) cr_inc[cr_ovc] = 1'b1;
        for (int v = 0; v < NVC; v++)
            if (pop[v]) cr_dec[ovc[v]] = 1'b1;
    end

    vcu_credit_bank #(.NOVC(NOVC), .CRED_MAX(CRED_MAX)) u_credits (
        .clk(clk), .rst(rst),
        .inc(cr_inc), .dec(cr_dec), .has_credit(has_credit)
    );

    always_comb begin
        out_valid = 1'b0;
        out_kind  = '0;
        out_data  = '0;
        out_port  = '0;
        out_ovc   = '0;
        for (int v = 0; v < NVC; v++) begin
            if (pop[v]) begin
                out_valid = 1'b1;
                {out_kind, out_data} = head[v];
                out_port = route[v];
                out_ovc  = ovc[v];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)               overflow <= 1'b0;
        else if (|push_lost)   overflow <= 1'b1;
    end

    AST_ONE_SWITCH_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sa_grant));                                          // R6
    AST_GRANT_FOLLOWS_BID: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $countones(sa_grant & sa_bid) == 1);            // R5
    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);                                       // R11

endmodule

// File: tb/tb_vcu_input_unit.sv
module tb_vcu_input_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [0:0]  in_vc;
    logic [1:0]  in_kind;
    logic [15:0] in_data;
    logic [1:0]  rc_req, rc_done, va_req, va_grant, sa_bid, sa_grant;
    logic [1:0]  rc_port, va_ovc, cr_ovc;
    logic        cr_valid;
    logic        out_valid;
    logic [1:0]  out_kind, out_port, out_ovc;
    logic [15:0] out_data;
    logic        overflow;

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic [1:0]  k;
        logic [15:0] d;
        logic [1:0]  p;
        logic [1:0]  o;
    } exp_t;
    exp_t q0[$];
    exp_t q1[$];

    always #5 clk = ~clk;

    vcu_input_unit dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_vc(in_vc), .in_kind(in_kind), .in_data(in_data),
        .rc_req(rc_req), .rc_done(rc_done), .rc_port(rc_port),
        .va_req(va_req), .va_grant(va_grant), .va_ovc(va_ovc),
        .sa_bid(sa_bid), .sa_grant(sa_grant),
        .cr_valid(cr_valid), .cr_ovc(cr_ovc),
        .out_valid(out_valid), .out_kind(out_kind), .out_data(out_data),
        .out_port(out_port), .out_ovc(out_ovc), .overflow(overflow)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Monitor: compares each forwarded flit with the scoreboard (R3 R4 R6)
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            exp_t e;
            logic have;
            have = 1'b0;
            if (sa_grant[0] && q0.size() > 0) begin e = q0.pop_front(); have = 1'b1; end
            else if (sa_grant[1] && q1.size() > 0) begin e = q1.pop_front(); have = 1'b1; end
            chk(have, "R6 unexpected flit", int'(out_data), 0);
            if (have) begin
                chk(out_data == e.d && out_kind == e.k, "R6 flit order", int'({out_kind, out_data}), int'({e.k, e.d}));
                chk(out_port == e.p, "R3 out_port", int'(out_port), int'(e.p));
                chk(out_ovc == e.o, "R4 out_ovc", int'(out_ovc), int'(e.o));
            end
        end
        if (!rst && (|sa_grant) && !out_valid)
            chk(1'b0, "R6 grant without flit", 0, 1);
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic send(input int vc, input logic [1:0] k, input logic [15:0] d,
                        input logic [1:0] p, input logic [1:0] o, input bit keep);
        exp_t e;
        in_valid = 1'b1; in_vc = vc[0:0]; in_kind = k; in_data = d;
        e = '{k: k, d: d, p: p, o: o};
        if (keep) begin
            if (vc == 0) q0.push_back(e); else q1.push_back(e);
        end
        step();
        in_valid = 1'b0;
    endtask

    task automatic activate(input int vc, input logic [1:0] p, input logic [1:0] o);
        chk(rc_req[vc] == 1'b1, "R2 routing request", int'(rc_req[vc]), 1);
        rc_done[vc] = 1'b1; rc_port = p;
        step();
        rc_done = '0;
        chk(va_req[vc] == 1'b1 && rc_req[vc] == 1'b0, "R3 waiting for VC", int'(va_req[vc]), 1);
        va_grant[vc] = 1'b1; va_ovc = o;
        step();
        va_grant = '0;
        chk(va_req[vc] == 1'b0, "R4 active after grant", int'(va_req[vc]), 0);
    endtask

    task automatic grant(input int vc, input bit with_credit, input logic [1:0] co);
        chk(sa_bid[vc] == 1'b1, "R5 bid before grant", int'(sa_bid[vc]), 1);
        sa_grant[vc] = 1'b1;
        cr_valid = with_credit; cr_ovc = co;
        step();
        sa_grant = '0; cr_valid = 1'b0;
    endtask

    task automatic give_credit(input logic [1:0] co);
        cr_valid = 1'b1; cr_ovc = co;
        step();
        cr_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1; in_valid = 0; in_vc = 0; in_kind = 0; in_data = 0;
        rc_done = 0; rc_port = 0; va_grant = 0; va_ovc = 0;
        sa_grant = 0; cr_valid = 0; cr_ovc = 0;
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1: reset state
        chk(rc_req == 0 && va_req == 0 && sa_bid == 0 && !out_valid && !overflow,
            "R1 reset state", int'({rc_req, va_req, sa_bid}), 0);

        // Packet A on VC0: port 2, output VC 1, four flits uses all four credits
        send(0, 2'b00, 16'hA000, 2'd2, 2'd1, 1);
        activate(0, 2'd2, 2'd1);
        send(0, 2'b01, 16'hA001, 2'd2, 2'd1, 1);
        // R10: a body flit at an active VC raises no request
        chk(rc_req[0] == 0 && va_req[0] == 0, "R10 body no request", int'({rc_req[0], va_req[0]}), 0);
        send(0, 2'b01, 16'hA002, 2'd2, 2'd1, 1);
        send(0, 2'b10, 16'hA003, 2'd2, 2'd1, 1);
        chk(rc_req[0] == 0 && va_req[0] == 0, "R10 tail no request", int'({rc_req[0], va_req[0]}), 0);
        for (int i = 0; i < 4; i++) grant(0, 0, 2'd0);
        // R9: tail left an empty buffer, VC goes idle
        chk(rc_req[0] == 0 && va_req[0] == 0 && sa_bid[0] == 0, "R9 idle after tail",
            int'({rc_req[0], va_req[0], sa_bid[0]}), 0);

        // Packet B on VC0 to output VC 1, which has no credit left
        send(0, 2'b00, 16'hB000, 2'd1, 2'd1, 1);
        send(0, 2'b01, 16'hB001, 2'd1, 2'd1, 1);
        send(0, 2'b10, 16'hB002, 2'd1, 2'd1, 1);
        activate(0, 2'd1, 2'd1);
        chk(sa_bid[0] == 0, "R5 no bid without credit", int'(sa_bid[0]), 0);
        give_credit(2'd1);
        chk(sa_bid[0] == 1, "R7 credit return enables bid", int'(sa_bid[0]), 1);
        grant(0, 1, 2'd1);   // grant and credit return on the same output VC
        chk(sa_bid[0] == 1, "R8 credit unchanged on grant plus return", int'(sa_bid[0]), 1);
        grant(0, 0, 2'd0);
        chk(sa_bid[0] == 0, "R5 credit exhausted stops bid", int'(sa_bid[0]), 0);
        give_credit(2'd1);
        grant(0, 0, 2'd0);
        chk(rc_req[0] == 0 && sa_bid[0] == 0, "R9 idle after packet B", int'({rc_req[0], sa_bid[0]}), 0);

        // Two packets queued on VC1: next head waits behind the tail
        send(1, 2'b00, 16'hC000, 2'd1, 2'd2, 1);
        send(1, 2'b10, 16'hC001, 2'd1, 2'd2, 1);
        send(1, 2'b00, 16'hD000, 2'd3, 2'd2, 1);
        send(1, 2'b10, 16'hD001, 2'd3, 2'd2, 1);
        activate(1, 2'd1, 2'd2);
        grant(1, 0, 2'd0);
        grant(1, 0, 2'd0);
        chk(rc_req[1] == 1, "R9 next head goes to routing", int'(rc_req[1]), 1);
        chk(rc_req[0] == 0, "R1 VC0 stays idle", int'(rc_req[0]), 0);
        activate(1, 2'd3, 2'd2);
        grant(1, 0, 2'd0);
        grant(1, 0, 2'd0);
        chk(rc_req[1] == 0 && sa_bid[1] == 0, "R9 idle after second packet", int'({rc_req[1], sa_bid[1]}), 0);

        // Overflow on VC1: fifth flit into a full buffer is dropped
        chk(overflow == 0, "R11 no overflow yet", int'(overflow), 0);
        send(1, 2'b00, 16'hE000, 2'd0, 2'd3, 1);
        send(1, 2'b01, 16'hE001, 2'd0, 2'd3, 1);
        send(1, 2'b01, 16'hE002, 2'd0, 2'd3, 1);
        send(1, 2'b10, 16'hE003, 2'd0, 2'd3, 1);
        send(1, 2'b01, 16'hEBAD, 2'd0, 2'd3, 0);
        chk(overflow == 1, "R11 overflow set", int'(overflow), 1);
        repeat (3) step();
        chk(overflow == 1, "R11 overflow sticky", int'(overflow), 1);
        activate(1, 2'd0, 2'd3);
        for (int i = 0; i < 4; i++) grant(1, 0, 2'd0);
        chk(sa_bid[1] == 0 && rc_req[1] == 0, "R11 dropped flit absent", int'({sa_bid[1], rc_req[1]}), 0);
        chk(q0.size() == 0 && q1.size() == 0, "R6 all flits forwarded",
            q0.size() + q1.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule